// File: doc/BRIEF.md
# Configurable asynchronous serial transceiver

This block is a full-duplex asynchronous serial port for a chip's peripheral bus. Its transmitter and receiver run at the same time and do not depend on each other. Each direction pairs a one-byte holding register with a shift register, so characters can stream back to back with no idle time between frames. A shared divider produces a tick at sixteen times the bit rate. The receiver oversamples the line with this tick: it confirms a start bit at mid-bit and then samples every later bit at its centre.

Software uses four byte-wide registers. It sets the character format: 7 or 8 data bits sent least-significant bit first, one or two stop bits, and even, odd or no parity. It also sets the divisor, writes transmit bytes, reads received bytes, and reads or clears the status. The receiver flags parity, overrun and framing errors. The synchronised level of the receive line can be read directly, so software can tell a break from an ordinary framing error. Four interrupt requests are each gated by their own enable: holding register empty, transmission finished, receive data present and receive error.

Top module: `async_serial_port`

## Requirements
- R1: After reset, txd is high and status reads 0x43: bit0 holding-empty=1, bit1 transmit-finished=1, bit6 receive-line=1, all other bits 0. The control register reads 0 and all four interrupt outputs are low.
- R2: A frame on txd is one low start bit, then the data bits least-significant first (7 when control bit0 is 1, otherwise 8), then the parity bit when control bit2 is 1, then high stop bits (2 when control bit1 is 1, otherwise 1). Each bit lasts 16*(divisor+1) clocks, and txd is high between frames.
- R3: The parity bit is the XOR of the data bits (even parity) when control bit3 is 0, and its inverse (odd parity) when control bit3 is 1.
- R4: A write to address 2 fills the transmit holding register and clears status bit0. The holding register moves into the shifter on the next tick, which sets bit0 again. A second byte written while the first is being sent starts exactly one frame length after the first, with no gap.
- R5: Status bit1 (transmit-finished) is cleared by a write to address 2. It sets only at the end of the last stop bit, and only if the holding register is empty at that moment.
- R6: A received character is stored in the receive buffer and sets status bit2. A read of address 2 returns the data, with bit7 forced to 0 in 7-bit mode, and clears bit2. Reception works while a transmission is in progress.
- R7: A character whose parity bit does not match the selected parity sets status bit5. The data is still stored.
- R8: A character whose first stop bit is sampled low sets status bit4. The data is still stored.
- R9: A character that completes while status bit2 is still set sets status bit3. The new character is discarded and the buffered character is kept.
- R10: Status bit6 shows the receive line level after a two-flop synchroniser.
- R11: Writing 1 to status bits 3, 4 or 5 at address 3 clears the matching error flag. Writing 0 leaves it unchanged.
- R12: Control bits 4, 5, 6 and 7 enable the interrupt outputs for holding-empty, transmit-finished, receive-data-present and any-receive-error. An interrupt output is high only while its flag is set and its enable is 1.
- R13: A low pulse on rxd that is shorter than half a bit is rejected as a false start and produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of address 2 consumes the received byte) |
| bus_addr | input | 2 | Register address: 0 control, 1 divisor, 2 data, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles high |
| irq_tx_empty | output | 1 | Holding register empty request |
| irq_tx_end | output | 1 | Transmission finished request |
| irq_rx_full | output | 1 | Receive data present request |
| irq_rx_err | output | 1 | Receive error request |

## Verification
If the transmit shifter holds a wrong bit count or shifts a wrong pattern, txd goes wrong within one bit period: a misplaced parity or stop bit, or a second frame that starts late. A faulty receive sampler or buffer shows up as soon as a character completes, at the centre of its first stop bit: status bits 2 to 5 read wrong, or the byte read from address 2 is wrong. If the transmit-finished flag is mistimed, status bit1 reads high during the stop bit, or stays low after it. Each such fault appears within one frame time.

// File: rtl/asp_pkg.sv
package asp_pkg;

  localparam int FRAME_W = 12;  // start + 8 data + parity + 2 stop
  localparam int RXSR_W  = 10;  // 8 data + parity + first stop

  typedef struct packed {
    logic par_odd;
    logic par_en;
    logic stop2;
    logic len7;
  } frame_cfg_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

  function automatic logic [3:0] data_len(frame_cfg_t c);
    return c.len7 ? 4'd7 : 4'd8;
  endfunction

  function automatic logic [7:0] data_mask(frame_cfg_t c);
    return c.len7 ? 8'h7F : 8'hFF;
  endfunction

  function automatic logic parity_of(frame_cfg_t c, logic [7:0] d);
    return (^(d & data_mask(c))) ^ c.par_odd;
  endfunction

  function automatic logic [3:0] tx_len(frame_cfg_t c);
    return 4'd2 + data_len(c) + {3'd0, c.par_en} + {3'd0, c.stop2};
  endfunction

  function automatic logic [3:0] rx_len(frame_cfg_t c);
    return data_len(c) + {3'd0, c.par_en} + 4'd1;
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(frame_cfg_t c, logic [7:0] d);
    logic [FRAME_W-1:0] f;
    f    = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(data_len(c))) f[i+1] = d[i];
    end
    if (c.par_en) f[int'(data_len(c)) + 1] = parity_of(c, d);
    return f;
  endfunction

  function automatic logic [7:0] rx_data(frame_cfg_t c, logic [RXSR_W-1:0] s);
    return s[7:0] & data_mask(c);
  endfunction

  function automatic logic rx_par_bad(frame_cfg_t c, logic [RXSR_W-1:0] s);
    return c.par_en && (s[int'(data_len(c))] != parity_of(c, rx_data(c, s)));
  endfunction

  function automatic logic rx_stop_bad(frame_cfg_t c, logic [RXSR_W-1:0] s);
    return !s[int'(data_len(c)) + int'(c.par_en)];
  endfunction

endpackage

// File: rtl/asp_baud_gen.sv
module asp_baud_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/asp_tx.sv
module asp_tx
  import asp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  frame_cfg_t cfg,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       txd,
  output logic       tde,
  output logic       tend,
  output logic       busy
);
  logic [FRAME_W-1:0] sr;
  logic [3:0]         bits_left;
  logic [3:0]         tcnt;
  logic [7:0]         hold;
  logic               hold_full;
  logic               bit_end, last_bit, load;

  assign bit_end  = busy && tick && (tcnt == 4'd15);
  assign last_bit = bit_end && (bits_left == 4'd1);
  assign load     = tick && hold_full && (!busy || last_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '1;
      bits_left <= '0;
      tcnt      <= '0;
      busy      <= 1'b0;
    end else if (load) begin
      sr        <= build_frame(cfg, hold);
      bits_left <= tx_len(cfg);
      tcnt      <= '0;
      busy      <= 1'b1;
    end else if (last_bit) begin
      busy      <= 1'b0;
      tcnt      <= '0;
    end else if (bit_end) begin
      sr        <= {1'b1, sr[FRAME_W-1:1]};
      bits_left <= bits_left - 4'd1;
      tcnt      <= '0;
    end else if (busy && tick) begin
      tcnt      <= tcnt + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
      tend      <= 1'b1;
    end else begin
      if (wr) hold <= wdata;
      if (wr) hold_full <= 1'b1;
      else if (load) hold_full <= 1'b0;
      if (wr) tend <= 1'b0;
      else if (last_bit && !hold_full) tend <= 1'b1;
    end
  end

  assign txd = busy ? sr[0] : 1'b1;
  assign tde = !hold_full;
endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import asp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  frame_cfg_t cfg,
  input  logic       rxd,
  input  logic       rd_clr,
  input  logic [2:0] clr_err,   // [0] overrun, [1] framing, [2] parity
  output logic       rx_line,
  output logic       done,
  output logic       rdf,
  output logic       ovr,
  output logic       fer,
  output logic       per,
  output logic [7:0] rx_buf
);
  logic              s1, s2;
  rx_state_t         state;
  logic [3:0]        tcnt;
  logic [3:0]        idx;
  logic [RXSR_W-1:0] sr;
  logic              rdf_live, keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      state <= RX_IDLE;
      tcnt  <= '0;
      idx   <= '0;
      sr    <= '1;
      done  <= 1'b0;
    end else begin
      s1   <= rxd;
      s2   <= s1;
      done <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: if (!s2) begin
            state <= RX_START;
            tcnt  <= '0;
          end
          RX_START: if (tcnt == 4'd7) begin
            tcnt  <= '0;
            idx   <= '0;
            state <= s2 ? RX_IDLE : RX_BITS;
          end else begin
            tcnt <= tcnt + 4'd1;
          end
          RX_BITS: begin
            tcnt <= tcnt + 4'd1;
            if (tcnt == 4'd15) begin
              sr[idx] <= s2;
              idx     <= idx + 4'd1;
              if (idx == rx_len(cfg) - 4'd1) begin
                state <= RX_IDLE;
                done  <= 1'b1;
              end
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign rx_line  = s2;
  assign rdf_live = rdf && !rd_clr;
  assign keep     = done && !rdf_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdf    <= 1'b0;
      ovr    <= 1'b0;
      fer    <= 1'b0;
      per    <= 1'b0;
      rx_buf <= '0;
    end else begin
      rdf <= keep || rdf_live;
      ovr <= (ovr && !clr_err[0]) || (done && rdf_live);
      fer <= (fer && !clr_err[1]) || (keep && rx_stop_bad(cfg, sr));
      per <= (per && !clr_err[2]) || (keep && rx_par_bad(cfg, sr));
      if (keep) rx_buf <= rx_data(cfg, sr);
    end
  end
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
  import asp_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       irq_tx_empty,
  output logic       irq_tx_end,
  output logic       irq_rx_full,
  output logic       irq_rx_err
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DIV  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  logic [7:0]       ctrl;
  logic [DIV_W-1:0] div;
  frame_cfg_t       cfg;
  logic             tick;
  logic             data_wr, data_rd, stat_wr;
  logic [2:0]       clr_err;
  logic             tx_tde, tx_tend, tx_busy;
  logic             rx_line, rx_done, rx_rdf, rx_ovr, rx_fer, rx_per;
  logic [7:0]       rx_buf;
  logic [7:0]       status;

  assign cfg     = frame_cfg_t'(ctrl[3:0]);
  assign data_wr = bus_wr && (bus_addr == A_DATA);
  assign data_rd = bus_rd && (bus_addr == A_DATA);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign clr_err = stat_wr ? bus_wdata[5:3] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      div  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) ctrl <= bus_wdata;
      if (bus_addr == A_DIV)  div  <= DIV_W'(bus_wdata);
    end
  end

  asp_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(div), .tick(tick)
  );

  asp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .wr(data_wr),
    .wdata(bus_wdata), .txd(txd), .tde(tx_tde), .tend(tx_tend), .busy(tx_busy)
  );

  asp_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .rxd(rxd),
    .rd_clr(data_rd), .clr_err(clr_err), .rx_line(rx_line), .done(rx_done),
    .rdf(rx_rdf), .ovr(rx_ovr), .fer(rx_fer), .per(rx_per), .rx_buf(rx_buf)
  );

  assign status = {1'b0, rx_line, rx_per, rx_fer, rx_ovr, rx_rdf, tx_tend, tx_tde};

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl;
      A_DIV:   bus_rdata = 8'(div);
      A_DATA:  bus_rdata = rx_buf;
      default: bus_rdata = status;
    endcase
  end

  assign irq_tx_empty = ctrl[4] && tx_tde;
  assign irq_tx_end   = ctrl[5] && tx_tend;
  assign irq_rx_full  = ctrl[6] && rx_rdf;
  assign irq_rx_err   = ctrl[7] && (rx_ovr || rx_fer || rx_per);
endmodule

// File: rtl/asp_checker.sv
module asp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       data_wr,
  input logic       data_rd,
  input logic       tx_busy,
  input logic       tx_tde,
  input logic       tx_tend,
  input logic       rx_done,
  input logic       rx_rdf,
  input logic       rx_ovr,
  input logic [7:0] rx_buf,
  input logic       irq_tx_end
);
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);  // R2
  AST_TDE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !tx_tde);  // R4
  AST_TEND_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !tx_tend);  // R5
  AST_TEND_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tend |-> (tx_tde && !tx_busy));  // R5
  AST_RDF_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_rdf);  // R6
  AST_RDF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rx_done) |=> !rx_rdf);  // R6
  AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_rdf && !data_rd) |=> (rx_ovr && $stable(rx_buf)));  // R9
  AST_IRQ_TEND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_end |-> tx_tend);  // R12
endmodule

bind async_serial_port asp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .data_wr(data_wr), .data_rd(data_rd),
  .tx_busy(tx_busy), .tx_tde(tx_tde), .tx_tend(tx_tend), .rx_done(rx_done),
  .rx_rdf(rx_rdf), .rx_ovr(rx_ovr), .rx_buf(rx_buf), .irq_tx_end(irq_tx_end)
);

// File: tb/async_serial_port_bench.sv
module async_serial_port_bench;
  localparam int DIVV = 1;
  localparam int P    = 16 * (DIVV + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic rxd = 1'b1;
  logic txd, irq_tx_empty, irq_tx_end, irq_rx_full, irq_rx_err;

  always #10 clk = ~clk;

  async_serial_port u_async_serial_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd),
    .irq_tx_empty(irq_tx_empty), .irq_tx_end(irq_tx_end),
    .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err)
  );

  int n_checks = 0, n_errs = 0;
  int cyc = 0;
  int frames_seen = 0;
  bit mon_busy = 0;
  bit m_len7 = 0, m_stop2 = 0, m_pe = 0, m_odd = 0;
  logic [7:0] exp_q[$];
  int start_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic set_cfg(input bit l7, input bit s2, input bit pe, input bit odd, input logic [3:0] ie);
    m_len7 = l7; m_stop2 = s2; m_pe = pe; m_odd = odd;
    bus_write(2'd0, {ie, odd, pe, s2, l7});
  endtask

  task automatic tx_byte(input logic [7:0] d);
    exp_q.push_back(d);
    bus_write(2'd2, d);
  endtask

  task automatic wait_frames(input int n);
    while (frames_seen < n) @(negedge clk);
  endtask

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (P) @(negedge clk);
  endtask

  // drives one character on rxd in the current format
  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int dl;
    logic [7:0] msk;
    dl  = m_len7 ? 7 : 8;
    msk = m_len7 ? 8'h7F : 8'hFF;
    @(negedge clk);
    hold_bit(1'b0);
    for (int i = 0; i < dl; i++) hold_bit(d[i]);
    if (m_pe) hold_bit(((^(d & msk)) ^ m_odd) ^ bad_par);
    if (bad_stop) begin
      rxd = 1'b0;
      repeat (P * 3 / 4) @(negedge clk);
      rxd = 1'b1;
      repeat (P) @(negedge clk);
    end else begin
      hold_bit(1'b1);
    end
    if (m_stop2) hold_bit(1'b1);
    repeat (4) @(negedge clk);
  endtask

  // behavioural line monitor for txd
  initial begin
    int dl;
    logic [7:0] d, e, msk;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        mon_busy = 1;
        start_q.push_back(cyc);
        dl  = m_len7 ? 7 : 8;
        msk = m_len7 ? 8'h7F : 8'hFF;
        d   = '0;
        repeat (P / 2) @(negedge clk);
        check(txd == 1'b0, "R2 start bit", txd, 0);
        for (int i = 0; i < dl; i++) begin
          repeat (P) @(negedge clk);
          d[i] = txd;
        end
        if (exp_q.size() > 0) e = exp_q.pop_front();
        else e = 8'h00;
        check(d == (e & msk), "R2 data bits", d, e & msk);
        if (m_pe) begin
          repeat (P) @(negedge clk);
          check(txd == ((^(e & msk)) ^ m_odd), "R3 parity bit", txd, (^(e & msk)) ^ m_odd);
        end
        repeat (P) @(negedge clk);
        check(txd == 1'b1, "R2 stop bit 1", txd, 1);
        if (m_stop2) begin
          repeat (P) @(negedge clk);
          check(txd == 1'b1, "R2 stop bit 2", txd, 1);
        end
        frames_seen++;
        mon_busy = 0;
      end
    end
  end

  // per-clock comparison: with nothing queued and no frame in flight the line idles high
  always @(negedge clk) begin
    if (rst_n && !mon_busy && exp_q.size() == 0)
      check(txd == 1'b1, "R2 idle line", txd, 1);
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_errs++; n_checks++;
    $display("FAIL watchdog expired, all requirements actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int base;
    repeat (5) @(negedge clk);
    check(txd == 1'b1, "R1 txd after reset", txd, 1);
    check({irq_tx_empty, irq_tx_end, irq_rx_full, irq_rx_err} == 4'b0, "R1 irqs low", 0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(2'd3, v);
    check(v == 8'h43, "R1 status after reset", v, 8'h43);
    bus_read(2'd0, v);
    check(v == 8'h00, "R1 control after reset", v, 0);

    bus_write(2'd1, 8'(DIVV));

    // 8N1 transmit and transmit-finished timing
    set_cfg(0, 0, 0, 0, 4'h0);
    tx_byte(8'hA5);
    bus_read(2'd3, v);
    check(v[1] == 1'b0, "R5 finished cleared by write", v[1], 0);
    wait_frames(1);
    bus_read(2'd3, v);
    check(v[1] == 1'b0, "R5 finished low during stop bit", v[1], 0);
    repeat (P) @(negedge clk);
    bus_read(2'd3, v);
    check(v[1:0] == 2'b11, "R5 finished after last stop", v[1:0], 3);

    // 7 bits, even parity, 2 stops
    set_cfg(1, 1, 1, 0, 4'h0);
    tx_byte(8'h3C);
    wait_frames(2);
    repeat (2 * P) @(negedge clk);

    // 8 bits odd parity
    set_cfg(0, 0, 1, 1, 4'h0);
    tx_byte(8'h81);
    wait_frames(3);
    repeat (P) @(negedge clk);

    // back-to-back transmit
    set_cfg(0, 0, 0, 0, 4'h0);
    base = start_q.size();
    tx_byte(8'h11);
    repeat (4) @(negedge clk);
    tx_byte(8'h22);
    bus_read(2'd3, v);
    check(v[0] == 1'b0, "R4 holding full while shifting", v[0], 0);
    wait_frames(5);
    check(start_q[base + 1] - start_q[base] == 10 * P, "R4 no gap between frames",
          start_q[base + 1] - start_q[base], 10 * P);
    repeat (P) @(negedge clk);
    bus_read(2'd3, v);
    check(v[0] == 1'b1, "R4 holding empty after transfer", v[0], 1);

    // receive 8N1
    send_frame(8'h5A, 0, 0);
    bus_read(2'd3, v);
    check((v & 8'h3C) == 8'h04, "R6 data present, no errors", v & 8'h3C, 8'h04);
    bus_read(2'd2, v);
    check(v == 8'h5A, "R6 received byte", v, 8'h5A);
    bus_read(2'd3, v);
    check(v[2] == 1'b0, "R6 read clears present flag", v[2], 0);

    // interrupts
    set_cfg(0, 0, 0, 0, 4'b0111);
    @(negedge clk);
    check(irq_tx_empty == 1'b1 && irq_tx_end == 1'b1, "R12 tx irqs enabled", {irq_tx_empty, irq_tx_end}, 3);
    check(irq_rx_full == 1'b0, "R12 rx irq idle", irq_rx_full, 0);
    send_frame(8'h33, 0, 0);
    check(irq_rx_full == 1'b1, "R12 rx irq raised", irq_rx_full, 1);
    bus_read(2'd2, v);
    @(negedge clk);
    check(irq_rx_full == 1'b0, "R12 rx irq dropped after read", irq_rx_full, 0);

    // overrun
    set_cfg(0, 0, 0, 0, 4'b1000);
    send_frame(8'h01, 0, 0);
    send_frame(8'h02, 0, 0);
    bus_read(2'd3, v);
    check(v[3] == 1'b1, "R9 overrun flag", v[3], 1);
    check(irq_rx_err == 1'b1, "R12 error irq", irq_rx_err, 1);
    bus_read(2'd2, v);
    check(v == 8'h01, "R9 first byte kept", v, 8'h01);
    bus_write(2'd3, 8'h00);
    bus_read(2'd3, v);
    check(v[3] == 1'b1, "R11 zero write keeps flag", v[3], 1);
    bus_write(2'd3, 8'h08);
    bus_read(2'd3, v);
    check(v[3] == 1'b0, "R11 overrun cleared", v[3], 0);
    check(irq_rx_err == 1'b0, "R12 error irq dropped", irq_rx_err, 0);

    // parity error, even parity
    set_cfg(0, 0, 1, 0, 4'h0);
    send_frame(8'h0F, 1, 0);
    bus_read(2'd3, v);
    check(v[5] == 1'b1, "R7 parity error", v[5], 1);
    bus_read(2'd2, v);
    check(v == 8'h0F, "R7 data kept", v, 8'h0F);
    bus_write(2'd3, 8'h38);
    set_cfg(0, 0, 1, 1, 4'h0);
    send_frame(8'h0F, 0, 0);
    bus_read(2'd3, v);
    check((v & 8'h3C) == 8'h04, "R7 good odd parity no error", v & 8'h3C, 8'h04);
    bus_read(2'd2, v);

    // framing error
    set_cfg(0, 0, 0, 0, 4'h0);
    send_frame(8'h77, 0, 1);
    bus_read(2'd3, v);
    check(v[4] == 1'b1, "R8 framing error", v[4], 1);
    bus_read(2'd2, v);
    check(v == 8'h77, "R8 data kept", v, 8'h77);
    bus_write(2'd3, 8'h38);

    // line level and short low pulse
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    bus_read(2'd3, v);
    check(v[6] == 1'b0, "R10 line low visible", v[6], 0);
    rxd = 1'b1;
    repeat (2 * P) @(negedge clk);
    bus_read(2'd3, v);
    check(v[6] == 1'b1, "R10 line high visible", v[6], 1);
    check(v[2] == 1'b0, "R13 short pulse rejected", v[2], 0);

    // 7-bit receive
    set_cfg(1, 0, 0, 0, 4'h0);
    send_frame(8'hD5, 0, 0);
    bus_read(2'd2, v);
    check(v == 8'h55, "R6 seven-bit receive", v, 8'h55);

    // full duplex
    set_cfg(0, 0, 0, 0, 4'h0);
    fork
      tx_byte(8'hC3);
      send_frame(8'h96, 0, 0);
    join
    wait_frames(6);
    bus_read(2'd2, v);
    check(v == 8'h96, "R6 receive during transmit", v, 8'h96);
    repeat (P) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule